// File: doc/BRIEF.md
# Instruction Fault Collector and Halt Controller

This block sits beside the execution pipeline of a small processing core and decides, once per completed instruction, whether the core carries on or stops. Each cycle in which an instruction completes (`step_i` high while the core is busy), it collects the fault strobes raised during that instruction into an 8-bit fault code. The strobes come from the data address checker, the call stack, the decoder, the loop unit and the memory and register integrity monitors. The block also checks the next program counter itself. If any fault bit is set, or if the instruction is an environment call asking for a clean stop, the block halts the core at the end of that cycle.

A halt raises `abort_o` in place of `commit_o` for that cycle, so the faulting instruction's pending changes are thrown away and it has no architectural effect. On the following edge the busy status drops, a one-cycle done interrupt pulse fires, and the merged fault code is captured into a register that software can read. A clean stop uses the same path with an all-zero code. A start command, accepted only while the core is idle, sets busy and clears the captured code.

All pins are plain control and status levels. The block moves no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `fault_halt_unit`

## Requirements
- R1: The fault code bit positions are: bit 0 bad data address, bit 1 bad instruction address, bit 2 call stack, bit 3 illegal instruction, bit 4 loop, bit 5 fatal instruction memory, bit 6 fatal data memory, bit 7 fatal register. All strobes raised in one completing cycle are ORed into one code, which appears on `err_code_o` on the edge that ends that cycle.
- R2: In a completing cycle with any fault bit set, `abort_o` is high and `commit_o` is low in that same cycle.
- R3: In a completing cycle with no fault and no environment call, `commit_o` is high and `abort_o` is low, and `busy_o` stays high. `commit_o` and `abort_o` are never high together.
- R4: A next PC whose two low bits are not both zero sets fault bit 1.
- R5: A next PC at or above `IMEM_BYTES` sets fault bit 1. The last aligned word below that limit does not.
- R6: An environment call with no fault halts the core (`abort_o` high, then busy low and a done pulse) and leaves `err_code_o` at zero.
- R7: After a halting cycle, `busy_o` is low from the next edge on, and `done_o` is high for exactly one cycle.
- R8: `err_code_o` holds its value until the next accepted start. A start while idle sets `busy_o` and clears `err_code_o` to zero on the next edge.
- R9: While idle, `step_i`, the fault strobes and `ecall_i` have no effect: `commit_o` and `abort_o` stay low and `err_code_o` is unchanged.
- R10: After reset, `busy_o`, `done_o`, `commit_o`, `abort_o` and `err_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, accepted while idle |
| step_i | input | 1 | An instruction completes in this cycle |
| next_pc_i | input | PC_W | Program counter of the next instruction |
| err_data_addr_i | input | 1 | Bad data address strobe |
| err_call_stack_i | input | 1 | Call stack overflow or underflow strobe |
| err_illegal_i | input | 1 | Illegal instruction strobe |
| err_loop_i | input | 1 | Loop misuse strobe |
| err_fatal_imem_i | input | 1 | Fatal instruction memory strobe |
| err_fatal_dmem_i | input | 1 | Fatal data memory strobe |
| err_fatal_reg_i | input | 1 | Fatal register file strobe |
| ecall_i | input | 1 | Environment call: clean stop request |
| commit_o | output | 1 | Commit the instruction's pending changes |
| abort_o | output | 1 | Discard the instruction's pending changes and halt |
| busy_o | output | 1 | Core running |
| done_o | output | 1 | One-cycle done interrupt pulse |
| err_code_o | output | 8 | Captured fault code |

## Verification
The bench builds the block with `IMEM_BYTES` = 256 and `PC_W` = 12. The small memory puts the upper limit well inside the PC's range, so addresses just below it (0x0FC), at it (0x100) and above it can all be driven directly. The limit check and the alignment check can then be seen separately and together. The same values keep every halt-and-restart round to a few cycles, so each code pattern in the table gets its own start.

// File: rtl/fault_halt_pkg.sv
package fault_halt_pkg;
  localparam int unsigned CODE_W = 8;

  localparam int unsigned B_DATA_ADDR  = 0;
  localparam int unsigned B_INSN_ADDR  = 1;
  localparam int unsigned B_CALL_STACK = 2;
  localparam int unsigned B_ILLEGAL    = 3;
  localparam int unsigned B_LOOP       = 4;
  localparam int unsigned B_FATAL_IMEM = 5;
  localparam int unsigned B_FATAL_DMEM = 6;
  localparam int unsigned B_FATAL_REG  = 7;

  localparam int unsigned PC_ALIGN_BITS = 2;

  typedef logic [CODE_W-1:0] fault_code_t;
endpackage

// File: rtl/fault_pc_check.sv
module fault_pc_check #(
  parameter int unsigned IMEM_BYTES = 4096,
  parameter int unsigned PC_W       = 16
) (
  input  logic [PC_W-1:0] next_pc_i,
  output logic            bad_o
);
  import fault_halt_pkg::*;

  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(IMEM_BYTES);

  logic misaligned;
  logic beyond;

  assign misaligned = |next_pc_i[PC_ALIGN_BITS-1:0];
  assign beyond     = {1'b0, next_pc_i} >= LIMIT;
  assign bad_o      = misaligned | beyond;
endmodule

// File: rtl/fault_merge.sv
module fault_merge (
  input  logic                        live_i,
  input  fault_halt_pkg::fault_code_t raw_i,
  input  logic                        ecall_i,
  output fault_halt_pkg::fault_code_t code_o,
  output logic                        halt_o,
  output logic                        commit_o
);
  logic any_fault;

  assign any_fault = |raw_i;
  assign code_o    = live_i ? raw_i : '0;
  assign halt_o    = live_i & (any_fault | ecall_i);
  assign commit_o  = live_i & ~any_fault & ~ecall_i;
endmodule

// File: rtl/fault_state.sv
module fault_state (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        halt_i,
  input  fault_halt_pkg::fault_code_t code_i,
  output logic                        busy_o,
  output logic                        done_o,
  output fault_halt_pkg::fault_code_t code_o
);
  logic                        busy_q;
  logic                        done_q;
  fault_halt_pkg::fault_code_t code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        code_q <= '0;
      end else if (busy_q && halt_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        code_q <= code_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;

  AST_HALT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && halt_i |=> !busy_q && done_q); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_CODE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start_i |=> $stable(code_q)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && start_i |=> busy_q && code_q == '0); // R8
endmodule

// File: rtl/fault_halt_unit.sv
module fault_halt_unit #(
  parameter int unsigned IMEM_BYTES = 4096,
  parameter int unsigned PC_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            step_i,
  input  logic [PC_W-1:0] next_pc_i,
  input  logic            err_data_addr_i,
  input  logic            err_call_stack_i,
  input  logic            err_illegal_i,
  input  logic            err_loop_i,
  input  logic            err_fatal_imem_i,
  input  logic            err_fatal_dmem_i,
  input  logic            err_fatal_reg_i,
  input  logic            ecall_i,
  output logic            commit_o,
  output logic            abort_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      err_code_o
);
  import fault_halt_pkg::*;

  logic        pc_bad;
  logic        live;
  logic        halt;
  fault_code_t raw;
  fault_code_t code_now;
  fault_code_t code_held;

  fault_pc_check #(.IMEM_BYTES(IMEM_BYTES), .PC_W(PC_W)) u_pc_check (
    .next_pc_i (next_pc_i),
    .bad_o     (pc_bad)
  );

  always_comb begin
    raw               = '0;
    raw[B_DATA_ADDR]  = err_data_addr_i;
    raw[B_INSN_ADDR]  = pc_bad;
    raw[B_CALL_STACK] = err_call_stack_i;
    raw[B_ILLEGAL]    = err_illegal_i;
    raw[B_LOOP]       = err_loop_i;
    raw[B_FATAL_IMEM] = err_fatal_imem_i;
    raw[B_FATAL_DMEM] = err_fatal_dmem_i;
    raw[B_FATAL_REG]  = err_fatal_reg_i;
  end

  assign live = busy_o & step_i;

  fault_merge u_merge (
    .live_i   (live),
    .raw_i    (raw),
    .ecall_i  (ecall_i),
    .code_o   (code_now),
    .halt_o   (halt),
    .commit_o (commit_o)
  );

  fault_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .halt_i  (halt),
    .code_i  (code_now),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .code_o  (code_held)
  );

  assign abort_o    = halt;
  assign err_code_o = code_held;

  AST_COMMIT_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && abort_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !commit_o && !abort_o); // R9
  AST_BADPC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && step_i && next_pc_i[1:0] != 2'b00 |-> abort_o); // R4
  AST_FAULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> err_code_o == $past(raw)); // R1
endmodule

// File: tb/fault_halt_unit_bench.sv
module fault_halt_unit_bench;
  localparam int unsigned IMEM_BYTES = 256;
  localparam int unsigned PC_W       = 12;
  localparam int NVEC = 11;
  // {src[7:0] (bit1 unused), ecall, pc[11:0], exp_code[7:0], exp_halt}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 12'h010, 8'h00, 1'b0},
    {8'h01, 1'b0, 12'h014, 8'h01, 1'b1},
    {8'h04, 1'b0, 12'h020, 8'h04, 1'b1},
    {8'h18, 1'b0, 12'h024, 8'h18, 1'b1},
    {8'hE0, 1'b0, 12'h028, 8'hE0, 1'b1},
    {8'h00, 1'b1, 12'h02C, 8'h00, 1'b1},
    {8'h00, 1'b0, 12'h102, 8'h02, 1'b1},
    {8'h00, 1'b0, 12'h0FC, 8'h00, 1'b0},
    {8'h00, 1'b0, 12'h100, 8'h02, 1'b1},
    {8'h00, 1'b0, 12'h0A1, 8'h02, 1'b1},
    {8'h09, 1'b1, 12'h0A3, 8'h0B, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, step = 1'b0, ecall = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic [7:0] src = '0;
  logic commit, abort, busy, done;
  logic [7:0] code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fault_halt_unit #(.IMEM_BYTES(IMEM_BYTES), .PC_W(PC_W)) u_fault_halt_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .step_i(step), .next_pc_i(pc),
    .err_data_addr_i(src[0]), .err_call_stack_i(src[2]), .err_illegal_i(src[3]),
    .err_loop_i(src[4]), .err_fatal_imem_i(src[5]), .err_fatal_dmem_i(src[6]),
    .err_fatal_reg_i(src[7]), .ecall_i(ecall), .commit_o(commit), .abort_o(abort),
    .busy_o(busy), .done_o(done), .err_code_o(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    chk(code == 8'h00, "R8 code cleared by start", code, 0);
  endtask

  task automatic run_vec(input logic [29:0] v, input string tag);
    logic [7:0] e_code;
    logic e_halt;
    e_code = v[8:1];
    e_halt = v[0];
    if (!busy) do_start();
    @(negedge clk);
    src = v[29:22]; ecall = v[21]; pc = v[20:9]; step = 1'b1;
    #1;
    chk(abort == e_halt, {tag, " R2 abort"}, abort, e_halt);
    chk(commit == !e_halt, {tag, " R3 commit"}, commit, !e_halt);
    @(negedge clk);
    step = 1'b0; src = '0; ecall = 1'b0;
    chk(busy == !e_halt, {tag, " R7 busy"}, busy, !e_halt);
    chk(done == e_halt, {tag, " R7 done"}, done, e_halt);
    if (e_halt) begin
      chk(code == e_code, {tag, " R1 code"}, code, e_code);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && commit == 0 && abort == 0 && code == 0,
        "R10 reset state", {busy, done, commit, abort, code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], $sformatf("vec%0d", i));
    // R6: environment call alone halts with zero code (vec5 also covers)
    do_start();
    run_vec({8'h00, 1'b1, 12'h040, 8'h00, 1'b1}, "R6 ecall");
    // R9: idle core ignores step and strobes; R8 code held
    run_vec({8'h10, 1'b0, 12'h040, 8'h10, 1'b1}, "R9 setup");
    @(negedge clk);
    src = 8'hFF; ecall = 1'b1; step = 1'b1; pc = 12'h101;
    #1;
    chk(abort == 0 && commit == 0, "R9 idle quiet", {abort, commit}, 0);
    @(negedge clk);
    step = 1'b0; src = '0; ecall = 1'b0;
    chk(code == 8'h10, "R9 code unchanged while idle", code, 8'h10);
    repeat (3) @(negedge clk);
    chk(code == 8'h10, "R8 code held until start", code, 8'h10);
    do_start();
    // R5 boundary: last word below limit commits
    run_vec({8'h00, 1'b0, 12'h0FC, 8'h00, 1'b0}, "R5 last word");
    run_vec({8'h00, 1'b0, 12'hFFC, 8'h02, 1'b1}, "R5 far above");
    // R4 alignment only
    run_vec({8'h00, 1'b0, 12'h012, 8'h02, 1'b1}, "R4 misaligned");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule